// File: doc/BRIEF.md
# Triple Edge-Triggered Storage Bit with Shared Controls

This block holds three independent one-bit storage elements. Each bit has its own data input and clock. It also has its own asynchronous set and clear. One common clock, one global set line and one global clear line serve all bits at once. Each bit drives a true output and a complement output.

A bit captures its data on the rising edge of its effective clock, which is the OR of its private clock and the common clock. Set and clear act at once and take precedence over any clock activity. When a set source and a clear source hit the same bit together, the bit enters a defined conflict state. In that state both outputs go to a fixed level and a per-bit flag is raised. All controls are active high, and a low level means idle.

Top module: `tdff_triple`

## Requirements
- R1: A rising edge on a bit's private clock, with the common clock low and no set or clear active, loads that bit's data input into its true output. A change of the data input with no clock edge leaves the outputs unchanged.
- R2: A rising edge on the common clock, with all private clocks low, loads every bit's data input into its true output.
- R3: While either of a bit's two clocks is high, a rising edge on the other one does not load new data.
- R4: Asserting a bit's own set drives that bit's true output high at once, without any clock, and leaves the other bits unchanged.
- R5: Asserting a bit's own clear drives that bit's true output low at once, without any clock, and leaves the other bits unchanged.
- R6: The global set drives every bit high, and the global clear drives every bit low.
- R7: While a set or clear source is active on a bit, clock edges do not change that bit's outputs.
- R8: Outside the conflict state, the complement output is always the inverse of the true output.
- R9: When any set source and any clear source are active on the same bit, both of its outputs sit at CONFLICT_LEVEL (default 1) and its conflict flag is 1. Otherwise the flag is 0.
- R10: When one side of a conflict is released, the side still asserted takes effect at once: a remaining set gives true output 1, and a remaining clear gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_in | input | NUM_BITS | Data input of each bit |
| clk_bit | input | NUM_BITS | Private clock of each bit |
| clk_common | input | 1 | Clock shared by all bits |
| set_bit | input | NUM_BITS | Asynchronous set of each bit |
| clr_bit | input | NUM_BITS | Asynchronous clear of each bit |
| set_all | input | 1 | Asynchronous set of all bits |
| clr_all | input | 1 | Asynchronous clear of all bits |
| q | output | NUM_BITS | True output of each bit |
| q_n | output | NUM_BITS | Complement output of each bit |
| conflict | output | NUM_BITS | Set/clear collision flag of each bit |

## Verification
At every rising edge of a bit's effective clock, the assertions check that an active lone set holds the bit high and an active lone clear holds it low. At every common-clock edge they check that the global set or global clear has reached all bits. Some behaviours can only be shown by the directed scenarios. These are: rejecting a second rising edge while the other clock is high, ignoring data changes between edges, the complement relation, the levels and flag in the conflict state, and which value wins when one side of a conflict is released.

// File: rtl/tdff_pkg.sv
package tdff_pkg;

   // Per-bit control bundle produced by the merge stage.
   typedef struct packed {
      logic clk_eff;   // OR of private and common clock
      logic set_only;  // some set source active, no clear source
      logic clr_only;  // some clear source active, no set source
      logic clash;     // set and clear sources active together
   } bit_ctrl_t;

endpackage

// File: rtl/tdff_ctrl_merge.sv
module tdff_ctrl_merge #(
   parameter int NUM_BITS = 3
) (
   input  logic                                  clk_common,
   input  logic                                  set_all,
   input  logic                                  clr_all,
   input  logic [NUM_BITS-1:0]                   clk_bit,
   input  logic [NUM_BITS-1:0]                   set_bit,
   input  logic [NUM_BITS-1:0]                   clr_bit,
   output tdff_pkg::bit_ctrl_t [NUM_BITS-1:0]   ctrl
);

   localparam int LAST_IDX = NUM_BITS - 1;

   generate
      if (NUM_BITS < 1) begin : g_bad_width
         $error("tdff_ctrl_merge: NUM_BITS must be at least 1");
      end
   endgenerate

   for (genvar gi = 0; gi <= LAST_IDX; gi++) begin : g_bit
      logic any_set;
      logic any_clr;

      assign any_set = set_bit[gi] | set_all;
      assign any_clr = clr_bit[gi] | clr_all;

      always_comb begin
         ctrl[gi].clk_eff  = clk_bit[gi] | clk_common;
         ctrl[gi].set_only = any_set & ~any_clr;
         ctrl[gi].clr_only = any_clr & ~any_set;
         ctrl[gi].clash    = any_set & any_clr;
      end
   end

endmodule

// File: rtl/tdff_store_bit.sv
module tdff_store_bit #(
   parameter bit CONFLICT_LEVEL = 1'b1
) (
   input  tdff_pkg::bit_ctrl_t ctrl,
   input  logic                d,
   output logic                q,
   output logic                q_n,
   output logic                clash_flag
);

   logic clk_eff;
   logic set_only;
   logic clr_only;
   logic clash;
   logic held;

   assign clk_eff  = ctrl.clk_eff;
   assign set_only = ctrl.set_only;
   assign clr_only = ctrl.clr_only;
   assign clash    = ctrl.clash;

   // The async terms rise whenever a lone source becomes effective,
   // including the moment the opposing side of a clash drops away.
   always_ff @(posedge clk_eff or posedge set_only or posedge clr_only) begin
      if (clr_only) begin
         held <= 1'b0;
      end else if (set_only) begin
         held <= 1'b1;
      end else if (!clash) begin
         held <= d;
      end
   end

   generate
      if (CONFLICT_LEVEL) begin : g_clash_high
         assign q   = clash | held;
         assign q_n = clash | ~held;
      end else begin : g_clash_low
         assign q   = ~clash & held;
         assign q_n = ~clash & ~held;
      end
   endgenerate

   assign clash_flag = clash;

   AST_SET_FORCES_HIGH: assert property (@(posedge clk_eff) disable iff (clash)
      set_only |-> q) else $error("lone set did not hold bit high"); // R4

   AST_CLEAR_FORCES_LOW: assert property (@(posedge clk_eff) disable iff (clash)
      clr_only |-> !q) else $error("lone clear did not hold bit low"); // R5

endmodule

// File: rtl/tdff_triple.sv
module tdff_triple #(
   parameter int NUM_BITS       = 3,
   parameter bit CONFLICT_LEVEL = 1'b1
) (
   input  logic [NUM_BITS-1:0] d_in,
   input  logic [NUM_BITS-1:0] clk_bit,
   input  logic                clk_common,
   input  logic [NUM_BITS-1:0] set_bit,
   input  logic [NUM_BITS-1:0] clr_bit,
   input  logic                set_all,
   input  logic                clr_all,
   output logic [NUM_BITS-1:0] q,
   output logic [NUM_BITS-1:0] q_n,
   output logic [NUM_BITS-1:0] conflict
);

   localparam int LAST_IDX = NUM_BITS - 1;
   localparam logic [NUM_BITS-1:0] ALL_ONES = {NUM_BITS{1'b1}};

   generate
      if (NUM_BITS < 1) begin : g_bad_width
         $error("tdff_triple: NUM_BITS must be at least 1");
      end
   endgenerate

   tdff_pkg::bit_ctrl_t [NUM_BITS-1:0] ctrl;

   tdff_ctrl_merge #(
      .NUM_BITS (NUM_BITS)
   ) merge_i (
      .clk_common (clk_common),
      .set_all    (set_all),
      .clr_all    (clr_all),
      .clk_bit    (clk_bit),
      .set_bit    (set_bit),
      .clr_bit    (clr_bit),
      .ctrl       (ctrl)
   );

   for (genvar gi = 0; gi <= LAST_IDX; gi++) begin : g_cell
      tdff_store_bit #(
         .CONFLICT_LEVEL (CONFLICT_LEVEL)
      ) cell_i (
         .ctrl       (ctrl[gi]),
         .d          (d_in[gi]),
         .q          (q[gi]),
         .q_n        (q_n[gi]),
         .clash_flag (conflict[gi])
      );
   end

   AST_MASTER_SET_ALL: assert property (@(posedge clk_common)
      (set_all && !clr_all && clr_bit == '0) |-> (q == ALL_ONES))
      else $error("global set missed a bit"); // R6

   AST_MASTER_CLR_ALL: assert property (@(posedge clk_common)
      (clr_all && !set_all && set_bit == '0) |-> (q == '0))
      else $error("global clear missed a bit"); // R6

endmodule

// File: tb/tdff_triple_tb.sv
module tdff_triple_tb_top;

   localparam int  N       = 3;
   localparam time CLK_P   = 10;
   localparam time HALF_P  = CLK_P / 2;
   localparam int  WDOG_CY = 200000;

   logic [N-1:0] d_in = '0;
   logic [N-1:0] clk_bit = '0;
   logic         clk_common = 1'b0;
   logic [N-1:0] set_bit = '0;
   logic [N-1:0] clr_bit = '0;
   logic         set_all = 1'b0;
   logic         clr_all = 1'b0;
   logic [N-1:0] q;
   logic [N-1:0] q_n;
   logic [N-1:0] conflict;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference state
   logic [N-1:0] exp_q  = '0;
   logic [N-1:0] exp_cf = '0;

   tdff_triple #(.NUM_BITS(N), .CONFLICT_LEVEL(1'b1)) dut_i (
      .d_in       (d_in),
      .clk_bit    (clk_bit),
      .clk_common (clk_common),
      .set_bit    (set_bit),
      .clr_bit    (clr_bit),
      .set_all    (set_all),
      .clr_all    (clr_all),
      .q          (q),
      .q_n        (q_n),
      .conflict   (conflict)
   );

   task automatic check_all(input string req);
      logic [N-1:0] want_qn;
      want_qn = ~exp_q | exp_cf;
      for (int i = 0; i < N; i++) begin
         if (exp_cf[i]) want_qn[i] = 1'b1;
      end
      n_tests++;
      if (q !== (exp_q | exp_cf) || q_n !== want_qn || conflict !== exp_cf) begin
         n_fail++;
         $display("FAIL %s: q=%b q_n=%b conflict=%b expected q=%b q_n=%b conflict=%b",
                  req, q, q_n, conflict, exp_q | exp_cf, want_qn, exp_cf);
      end
   endtask

   task automatic pulse_own(input int i);
      #HALF_P clk_bit[i] = 1'b1;
      #HALF_P clk_bit[i] = 1'b0;
      #HALF_P;
   endtask

   task automatic pulse_common();
      #HALF_P clk_common = 1'b1;
      #HALF_P clk_common = 1'b0;
      #HALF_P;
   endtask

   task automatic t_init_clear();
      clr_all = 1'b1;
      #HALF_P;
      exp_q = '0;
      check_all("R6 global clear from power-up");
      clr_all = 1'b0;
      #HALF_P;
      check_all("R6 state kept after global clear released");
   endtask

   task automatic t_own_clock();
      d_in = 3'b101;
      for (int i = 0; i < N; i++) begin
         pulse_own(i);
         exp_q[i] = d_in[i];
      end
      check_all("R1 capture on private clocks");
      d_in = 3'b010;
      #CLK_P;
      check_all("R1 data change without edge ignored");
      pulse_own(1);
      exp_q[1] = 1'b1;
      check_all("R1 private clock loads only its bit");
      check_all("R8 complement follows true output");
   endtask

   task automatic t_common_clock();
      d_in = 3'b100;
      pulse_common();
      exp_q = 3'b100;
      check_all("R2 common clock loads all bits");
      d_in = 3'b011;
      pulse_common();
      exp_q = 3'b011;
      check_all("R2 second common capture");
   endtask

   task automatic t_or_hold();
      d_in = 3'b000;
      #HALF_P clk_bit[0] = 1'b1;          // bit0 captures 0
      exp_q[0] = 1'b0;
      #HALF_P d_in = 3'b111;
      #HALF_P clk_common = 1'b1;          // bit0 blocked, bits1,2 capture 1
      exp_q[2:1] = 2'b11;
      #HALF_P;
      check_all("R3 common edge ignored while private clock high");
      clk_bit[0] = 1'b0;                  // OR still high via common
      #HALF_P clk_bit[0] = 1'b1;
      #HALF_P;
      check_all("R3 private edge ignored while common clock high");
      clk_bit[0] = 1'b0;
      clk_common = 1'b0;
      #HALF_P;
   endtask

   task automatic t_bit_overrides();
      set_bit[0] = 1'b1;
      #HALF_P;
      exp_q[0] = 1'b1;
      check_all("R4 own set forces bit high");
      d_in = 3'b000;
      pulse_own(0);
      pulse_common();
      exp_q[2:1] = 2'b00;
      check_all("R7 clock ignored while set active");
      set_bit[0] = 1'b0;
      clr_bit[2] = 1'b1;
      d_in = 3'b100;
      #HALF_P;
      check_all("R5 own clear on low bit keeps low");
      set_bit[1] = 1'b1;
      #HALF_P;
      exp_q[1] = 1'b1;
      check_all("R4 set affects only its bit");
      clr_bit[0] = 1'b1;
      #HALF_P;
      exp_q[0] = 1'b0;
      check_all("R5 own clear forces bit low");
      pulse_own(2);
      check_all("R7 clock ignored while clear active");
      clr_bit = '0;
      set_bit = '0;
      #HALF_P;
      check_all("R8 outputs after overrides released");
   endtask

   task automatic t_master_lines();
      set_all = 1'b1;
      #HALF_P;
      exp_q = 3'b111;
      check_all("R6 global set reaches all bits");
      set_all = 1'b0;
      d_in = 3'b010;
      pulse_common();
      exp_q = 3'b010;
      clr_all = 1'b1;
      #HALF_P;
      exp_q = 3'b000;
      check_all("R6 global clear reaches all bits");
      clr_all = 1'b0;
      #HALF_P;
   endtask

   task automatic t_conflict();
      set_bit[2] = 1'b1;
      #HALF_P;
      exp_q[2] = 1'b1;
      clr_all = 1'b1;
      #HALF_P;
      exp_q[1:0] = 2'b00;
      exp_cf = 3'b100;
      check_all("R9 bit set plus global clear gives clash");
      pulse_own(2);
      check_all("R9 clash state unchanged by clock");
      clr_all = 1'b0;
      #HALF_P;
      exp_cf = '0;
      exp_q[2] = 1'b1;
      check_all("R10 remaining set wins on release");
      set_bit[2] = 1'b0;
      #HALF_P;
      set_all = 1'b1;
      #HALF_P;
      exp_q = 3'b111;
      clr_bit[0] = 1'b1;
      #HALF_P;
      exp_cf = 3'b001;
      check_all("R9 global set plus bit clear gives clash");
      set_all = 1'b0;
      #HALF_P;
      exp_cf = '0;
      exp_q[0] = 1'b0;
      check_all("R10 remaining clear wins on release");
      clr_bit[0] = 1'b0;
      #HALF_P;
      check_all("R10 value kept after clear released");
   endtask

   initial begin
      #(CLK_P * WDOG_CY);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #CLK_P;
      t_init_clear();
      t_own_clock();
      t_common_clock();
      t_or_hold();
      t_bit_overrides();
      t_master_lines();
      t_conflict();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule